// File: doc/BRIEF.md
# Latency-Aware Re-Reference Replacement Controller

This block holds the replacement state for one set of an 8-way set-associative cache. Each way has a small re-reference counter. A smaller count means the line is more likely to be used again soon, so it is kept longer. A hit moves a way to the most-protected value. When the line is evicted, the victim is the lowest-numbered way whose counter is at the top value. If no way is at the top value, all counters age together, one step per cycle, until one of them reaches it.

A fill normally gives the new line the second-highest value. When the requesting core is flagged as having long dynamic link latency, the fill value is lowered by a bonus. The bonus is the product of the two interleaving counts plus one, times the link latency to the bank. That result is divided by the re-access interval times a scaling constant. Lines that came from distant banks therefore start closer to the protected end. They survive the extra traffic that arrives while they are in flight.

Tag and data arrays sit outside this block. The surrounding cache controller issues one request at a time. It waits for the victim result before sending the next request. Requests that arrive while aging is in progress are not accepted.

Top module: `lat_rrip_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every way's counter equals the top value 2^RW-1, and `victim_ready` is low with `victim_way` 0.
- R2: A hit request (`req_op` = 1) sets the addressed way's counter to 0.
- R3: A fill request (`req_op` = 2) with `long_lat` low sets the addressed way's counter to 2^RW-2, whatever the latency inputs are.
- R4: A fill with `long_lat` high sets the counter to 2^RW-2 minus B. B = ((inter × inner + 1) × link latency) / (re-access interval × SCALE), using integer division. For example, inter 4, inner 3, latency 2, interval 13 gives B = 2.
- R5: When B is 2^RW-2 or more, the inserted counter is clamped to 0.
- R6: A victim request (`req_op` = 3) returns the lowest-indexed way whose counter is at the top value.
- R7: If no way is at the top value, all counters rise by one each cycle until one reaches it. With a largest counter v, `victim_ready` rises 1 + (2^RW-1-v) cycles after the request edge.
- R8: `victim_ready` is a single-cycle pulse, given once per victim request.
- R9: A re-access interval of 0 is treated as a divisor of 1 when computing B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 1 hit, 2 fill, 3 victim select |
| req_way | input | 3 | Way addressed by hit or fill |
| link_lat | input | 4 | Link latency to the line's bank |
| inter_cnt | input | 4 | Interleaved lines from other programs |
| inner_cnt | input | 4 | Interleaved lines from the same program |
| reacc_cyc | input | 8 | Cycles between two accesses to the line |
| long_lat | input | 1 | Long dynamic latency detected |
| victim_way | output | 3 | Selected victim way |
| victim_ready | output | 1 | Victim result valid (one-cycle pulse) |

## Verification
The hardest case to reach is a multi-cycle aging run in which the ways sit at different counts. Reaching it needs a scripted sequence of hits and fills, including a latency-boosted fill, so that the highest counter is several steps below the top. Several ways also have to land on the top value together. The scoreboard keeps its own model of all eight counters. From that model it predicts both the victim way and the exact cycle of `victim_ready`. A clamped fill is then read back indirectly, by protecting every other way so that the clamped way's aging count sets the response time.

// File: rtl/lrr_pkg.sv
// Shared encodings for the latency-aware replacement controller.
package lrr_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2,
        OP_VICT = 2'd3
    } lrr_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_AGE  = 1'b1
    } lrr_state_e;
endpackage

// File: rtl/lrr_insert_calc.sv
// Computes the counter value given to a newly filled line.
// Assumes SCALE >= 1; a zero divisor is forced to 1; result clamps at 0.
module lrr_insert_calc #(
    parameter int RW    = 3,
    parameter int LAT_W = 4,
    parameter int CNT_W = 4,
    parameter int IVL_W = 8,
    parameter int SCALE = 1
) (
    input  logic [LAT_W-1:0] link_lat,
    input  logic [CNT_W-1:0] inter_cnt,
    input  logic [CNT_W-1:0] inner_cnt,
    input  logic [IVL_W-1:0] reacc_cyc,
    input  logic             long_lat,
    output logic [RW-1:0]    ins_val
);
    localparam int SC_W  = $clog2(SCALE + 1);
    localparam int NUM_W = 2 * CNT_W + 1 + LAT_W;
    localparam int DEN_W = IVL_W + SC_W;
    localparam int W     = (NUM_W > DEN_W) ? NUM_W : DEN_W;
    localparam int BASE  = (2 ** RW) - 2;

    logic [2*CNT_W-1:0] pair_prod;
    logic [NUM_W-1:0]   numer;
    logic [DEN_W-1:0]   denom;
    logic [W-1:0]       bonus;

    // Numerator and divisor of the latency bonus.
    always_comb begin
        pair_prod = (2*CNT_W)'(inter_cnt) * (2*CNT_W)'(inner_cnt);
        numer     = (NUM_W'(pair_prod) + NUM_W'(1)) * NUM_W'(link_lat);
        denom     = DEN_W'(reacc_cyc) * DEN_W'(SCALE);
        if (denom == '0) denom = DEN_W'(1);
    end

    // Divide, then subtract from the base value with a floor of zero.
    always_comb begin
        bonus = W'(numer) / W'(denom);
        if (!long_lat)
            ins_val = RW'(BASE);
        else if (bonus >= W'(BASE))
            ins_val = '0;
        else
            ins_val = RW'(W'(BASE) - bonus);
    end
endmodule

// File: rtl/lrr_top_find.sv
// Finds whether any way holds the top counter value and, if so, the
// lowest-indexed such way. Pure combinational priority search.
module lrr_top_find #(
    parameter int WAYS  = 8,
    parameter int RW    = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS*RW-1:0] rrpv_flat,
    output logic               any_top,
    output logic [WAY_W-1:0]   top_idx
);
    logic [WAYS-1:0] at_top;

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            // Compare each way against the all-ones top value.
            assign at_top[g] = (rrpv_flat[g*RW +: RW] == {RW{1'b1}});
        end
    endgenerate

    // Lowest index wins: scan downward so the last write is the smallest.
    always_comb begin
        any_top = |at_top;
        top_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (at_top[i]) top_idx = WAY_W'(i);
        end
    end
endmodule

// File: rtl/lat_rrip_ctrl.sv
// Replacement-state controller for one cache set. Hit, fill and victim
// requests are taken only in the idle state, one at a time. A victim search
// ages all ways by one per cycle until a way reaches the top value.
module lat_rrip_ctrl #(
    parameter int WAYS  = 8,
    parameter int RW    = 3,
    parameter int LAT_W = 4,
    parameter int CNT_W = 4,
    parameter int IVL_W = 8,
    parameter int SCALE = 1,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [WAY_W-1:0] req_way,
    input  logic [LAT_W-1:0] link_lat,
    input  logic [CNT_W-1:0] inter_cnt,
    input  logic [CNT_W-1:0] inner_cnt,
    input  logic [IVL_W-1:0] reacc_cyc,
    input  logic             long_lat,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_ready
);
    import lrr_pkg::*;

    logic [RW-1:0]      rrpv_q [WAYS];
    logic [WAYS*RW-1:0] rrpv_flat;
    logic [RW-1:0]      ins_val;
    logic               any_top;
    logic [WAY_W-1:0]   top_idx;
    lrr_state_e         state_q;
    lrr_op_e            op;
    logic               idle;

    assign op   = lrr_op_e'(req_op);
    assign idle = (state_q == ST_IDLE);

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_flat
            // Flatten the per-way counters for the search logic.
            assign rrpv_flat[g*RW +: RW] = rrpv_q[g];
        end
    endgenerate

    lrr_insert_calc #(
        .RW(RW), .LAT_W(LAT_W), .CNT_W(CNT_W), .IVL_W(IVL_W), .SCALE(SCALE)
    ) u_ins (
        .link_lat (link_lat),
        .inter_cnt(inter_cnt),
        .inner_cnt(inner_cnt),
        .reacc_cyc(reacc_cyc),
        .long_lat (long_lat),
        .ins_val  (ins_val)
    );

    lrr_top_find #(.WAYS(WAYS), .RW(RW)) u_find (
        .rrpv_flat(rrpv_flat),
        .any_top  (any_top),
        .top_idx  (top_idx)
    );

    // Request handling, victim search and aging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) rrpv_q[i] <= {RW{1'b1}};
            state_q      <= ST_IDLE;
            victim_way   <= '0;
            victim_ready <= 1'b0;
        end else begin
            victim_ready <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (req_valid) begin
                    case (op)
                        OP_HIT:  rrpv_q[req_way] <= '0;
                        OP_FILL: rrpv_q[req_way] <= ins_val;
                        OP_VICT: begin
                            if (any_top) begin
                                victim_way   <= top_idx;
                                victim_ready <= 1'b1;
                            end else begin
                                for (int i = 0; i < WAYS; i++)
                                    rrpv_q[i] <= rrpv_q[i] + RW'(1);
                                state_q <= ST_AGE;
                            end
                        end
                        default: ;
                    endcase
                end
            end else begin
                if (any_top) begin
                    victim_way   <= top_idx;
                    victim_ready <= 1'b1;
                    state_q      <= ST_IDLE;
                end else begin
                    for (int i = 0; i < WAYS; i++)
                        rrpv_q[i] <= rrpv_q[i] + RW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lrr_rrip_chk.sv
// Property checker for lat_rrip_ctrl, attached by bind. Observes the
// per-way counters and the controller's idle state.
module lrr_rrip_chk #(
    parameter int WAYS  = 8,
    parameter int RW    = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_op,
    input logic [WAY_W-1:0]   req_way,
    input logic               long_lat,
    input logic               idle,
    input logic [WAYS*RW-1:0] rrpv_flat,
    input logic [WAY_W-1:0]   victim_way,
    input logic               victim_ready
);
    localparam logic [RW-1:0] TOP = {RW{1'b1}};

    logic [RW-1:0] ways_a [WAYS];
    logic          some_top;

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_unp
            assign ways_a[g] = rrpv_flat[g*RW +: RW];
        end
    endgenerate

    // Independent top-value detection for the aging check.
    always_comb begin
        some_top = 1'b0;
        for (int i = 0; i < WAYS; i++)
            if (ways_a[i] == TOP) some_top = 1'b1;
    end

    // R1
    reset_all_top_chk: assert property (@(posedge clk)
        !rst_n |=> (rrpv_flat == {WAYS*RW{1'b1}}));

    // R2
    hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idle && req_op == 2'd1) |=> (ways_a[$past(req_way)] == '0));

    // R3
    fill_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idle && req_op == 2'd2 && !long_lat)
        |=> (ways_a[$past(req_way)] == TOP - RW'(1)));

    // R6
    victim_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_ready |-> (ways_a[victim_way] == TOP));

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_ready |=> !victim_ready);

    generate
        for (g = 0; g < WAYS; g++) begin : g_way
            // R7
            aging_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!idle && !some_top) |=> (ways_a[g] == $past(ways_a[g]) + RW'(1)));
            // R6
            lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (victim_ready && (WAY_W'(g) < victim_way)) |-> (ways_a[g] != TOP));
        end
    endgenerate
endmodule

bind lat_rrip_ctrl lrr_rrip_chk #(.WAYS(WAYS), .RW(RW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_way     (req_way),
    .long_lat    (long_lat),
    .idle        (idle),
    .rrpv_flat   (rrpv_flat),
    .victim_way  (victim_way),
    .victim_ready(victim_ready)
);

// File: tb/sim_lat_rrip_ctrl.sv
// Scoreboard bench: driver tasks model the eight counters, push the
// expected victim and response cycle; a monitor pops and compares.
module sim_lat_rrip_ctrl;
    localparam int WAYS = 8;
    localparam int RW   = 3;
    localparam int TOPV = (1 << RW) - 1;
    localparam int SCALE = 1;

    typedef struct {
        int    way;
        int    due;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [2:0] req_way = 3'd0;
    logic [3:0] link_lat = 4'd0;
    logic [3:0] inter_cnt = 4'd0;
    logic [3:0] inner_cnt = 4'd0;
    logic [7:0] reacc_cyc = 8'd0;
    logic       long_lat = 1'b0;
    logic [2:0] victim_way;
    logic       victim_ready;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   model [WAYS];
    exp_t sb_q [$];
    logic prev_ready = 1'b0;
    bit   mon_on = 1'b0;

    lat_rrip_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_way(req_way), .link_lat(link_lat), .inter_cnt(inter_cnt),
        .inner_cnt(inner_cnt), .reacc_cyc(reacc_cyc), .long_lat(long_lat),
        .victim_way(victim_way), .victim_ready(victim_ready)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int exp_ins(bit f, int ia, int ib, int lat, int ivl);
        int d;
        int b;
        d = ivl * SCALE;
        if (d == 0) d = 1;
        b = ((ia * ib + 1) * lat) / d;
        if (!f) return TOPV - 1;
        if (b >= TOPV - 1) return 0;
        return TOPV - 1 - b;
    endfunction

    task automatic send(input int op, input int w);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_way   = 3'(w);
        @(negedge clk);
        req_valid = 1'b0;
        req_op    = 2'd0;
    endtask

    // R2: hit drives model way to 0
    task automatic do_hit(input int w);
        model[w] = 0;
        send(1, w);
    endtask

    task automatic do_fill(input int w, input bit f, input int ia, input int ib,
                           input int lat, input int ivl);
        model[w]  = exp_ins(f, ia, ib, lat, ivl);
        long_lat  = f;
        inter_cnt = 4'(ia);
        inner_cnt = 4'(ib);
        link_lat  = 4'(lat);
        reacc_cyc = 8'(ivl);
        send(2, w);
    endtask

    task automatic do_victim(input string tag);
        int   mx;
        int   ag;
        exp_t e;
        mx = 0;
        for (int i = 0; i < WAYS; i++) if (model[i] > mx) mx = model[i];
        ag = TOPV - mx;
        for (int i = 0; i < WAYS; i++) model[i] += ag;
        e.way = -1;
        for (int i = WAYS - 1; i >= 0; i--) if (model[i] == TOPV) e.way = i;
        e.due = cyc + 1 + ag;
        e.tag = tag;
        sb_q.push_back(e);
        send(3, 0);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compares victim results and response cycle, checks pulse width.
    always @(negedge clk) begin
        if (mon_on) begin
            if (victim_ready && prev_ready)
                check(1'b0, "R8 ready held two cycles", 1, 0);
            if (victim_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8 unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(int'(victim_way) == e.way, {e.tag, " R6 victim way"},
                          int'(victim_way), e.way);
                    check(cyc == e.due, {e.tag, " R7 ready cycle"}, cyc, e.due);
                end
            end else if (sb_q.size() != 0 && cyc > sb_q[0].due) begin
                exp_t e;
                e = sb_q.pop_front();
                check(1'b0, {e.tag, " R7 ready missing"}, cyc, e.due);
            end
        end
        prev_ready = victim_ready;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #200000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < WAYS; i++) model[i] = TOPV;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(victim_ready == 1'b0, "R1 reset ready low", int'(victim_ready), 0);
        check(victim_way == 3'd0, "R1 reset victim way", int'(victim_way), 0);
        mon_on = 1'b1;

        // R1: all ways at top -> way 0 at once
        do_victim("R1 after reset");

        // R3: plain fills, latency inputs large but flag low
        for (int i = 0; i < WAYS; i++) do_fill(i, 1'b0, 15, 15, 15, 1);
        do_victim("R3/R7 single aging step");

        // R2: protect ways 0..2, victim is way 3
        do_hit(0); do_hit(1); do_hit(2);
        do_victim("R2/R6 hits protect low ways");

        // R4: bonus 2 -> insert 4, then three aging steps
        do_fill(3, 1'b1, 4, 3, 2, 13);
        for (int i = 4; i < WAYS; i++) do_hit(i);
        do_victim("R4 latency bonus multi-step aging");

        // R6: two ways reach top together, lowest wins
        do_fill(3, 1'b0, 0, 0, 0, 0);
        do_fill(5, 1'b0, 0, 0, 0, 0);
        do_victim("R6 tie lowest index");

        // R5: huge bonus clamps to 0; read back through aging count
        do_fill(6, 1'b1, 15, 15, 15, 1);
        for (int i = 0; i < WAYS; i++) if (i != 6) do_hit(i);
        do_fill(0, 1'b0, 0, 0, 0, 0);
        do_victim("R5 clamp step A");
        for (int i = 0; i < WAYS; i++) if (i != 6) do_hit(i);
        do_victim("R5 clamp step B");

        // R9: zero interval acts as divisor 1 -> bonus 3 -> insert 3
        do_fill(2, 1'b1, 0, 0, 3, 0);
        for (int i = 0; i < WAYS; i++) if (i != 2) do_hit(i);
        do_victim("R9 zero interval");

        // R8: no stray pulse after the last result
        repeat (4) @(negedge clk);
        check(victim_ready == 1'b0, "R8 idle ready low", int'(victim_ready), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule